// File: doc/BRIEF.md
# SPI Master with FIFO-Driven Chip Select

This block is a single-slave SPI master. Software-side logic pushes bytes into a 16-entry transmit queue. The shift engine takes them one at a time and sends them out most significant bit first on a serial clock made by dividing the system clock. The byte clocked back in from the slave lands in a 16-entry receive queue. The receive queue shows its oldest entry at the read port, so a read pops one byte.

Chip select is driven only by the state of the transmit path. It is active while a byte is being shifted or while the transmit queue holds data, and it goes inactive as soon as both are empty. For long bursts where the queue may run dry between refills, a force input holds chip select active across those gaps. Two level-sensitive interrupt outputs compare queue occupancy with programmable thresholds, and each has its own enable. Two sticky flags record bytes that were lost because a queue was full.

Top module: `spi_fifo_master`

## Requirements
- R1: Transfers use SPI mode 0 with 8-bit words, MSB first. `sclk` idles low. `mosi` changes only on falling edges of `sclk`, and the word's MSB is already present before the first rising edge. `miso` is sampled on rising edges.
- R2: One `sclk` period lasts `clk_div` system clock cycles, with `sclk` high for half of them. A `clk_div` below 2 behaves as 2.
- R3: Bytes go out on `mosi` in the order they were written. Received bytes are read back in arrival order: `rd_data` shows the oldest stored byte and `rd_en` removes it.
- R4: With `cs_force` low, `cs_n` is low while a byte is shifting or the transmit queue is non-empty. It is high in every other cycle. It returns high after the final bit of the last queued byte and goes low again on the next write.
- R5: When another byte is queued at the end of a word, the next word starts with no idle `sclk` time. Across a whole burst, no rising-edge interval exceeds one `sclk` period, and `cs_n` does not rise inside the burst.
- R6: While `cs_force` is high, `cs_n` is low, even when the shifter is idle and the transmit queue is empty.
- R7: `tx_irq` equals `tx_irq_en` AND (transmit queue count < `tx_level`). A byte leaves the count at the moment it is loaded into the shifter.
- R8: `rx_irq` equals `rx_irq_en` AND (receive queue count >= `rx_level`).
- R9: A write while the transmit queue holds 16 bytes is discarded (it is never sent) and sets `tx_ovf`. `tx_ovf` stays set until reset.
- R10: A byte that completes while the receive queue holds 16 bytes is discarded, and the stored bytes are kept. This sets `rx_ovf`, which stays set until reset.
- R11: `busy` is high while a byte is shifting or the transmit queue is non-empty.
- R12: After reset: `cs_n`=1, `sclk`=0, `busy`=0, `rx_empty`=1, both overflow flags are 0, and both queues are empty, so the interrupts follow R7 and R8 with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Pop the oldest received byte |
| rd_data | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue holds no bytes |
| clk_div | input | 8 | Serial clock divisor (even, at least 2) |
| tx_level | input | 5 | Transmit interrupt threshold |
| rx_level | input | 5 | Receive interrupt threshold |
| tx_irq_en | input | 1 | Enable for `tx_irq` |
| rx_irq_en | input | 1 | Enable for `rx_irq` |
| cs_force | input | 1 | Hold chip select active |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Shifting or transmit data pending |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_irq | output | 1 | Receive level interrupt |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
The main function is tried with four input patterns, and each one isolates a different behaviour:
- A lone byte after idle checks the measured `sclk` period and the return of chip select.
- Back-to-back writes during a running word check the gapless handover and the absence of chip-select pulses.
- Two writes separated by an idle period show that chip select rises between them in automatic mode and stays low with the force input.
- A stream of eighteen paced writes against a slow clock fills both queues to the limit. It shows that exactly one transmit byte and one receive byte are lost, and that no stored byte is disturbed.

A slave model returns a distinct byte per word, so byte order and bit order are both checked in each direction.

// File: rtl/spi_fifo_pkg.sv
`timescale 1ns/1ps
package spi_fifo_pkg;

  // Half period of the serial clock in system cycles; divisors below 2 act as 2.
  function automatic logic [15:0] sclk_half(input logic [15:0] div);
    return (div < 16'd2) ? 16'd1 : (div >> 1);
  endfunction

  // Occupancy strictly below a threshold.
  function automatic logic level_below(input logic [7:0] cnt, input logic [7:0] lvl);
    return cnt < lvl;
  endfunction

endpackage

// File: rtl/spi_word_fifo.sv
`timescale 1ns/1ps
module spi_word_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          dropped
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dropped = push && full;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CW'(DEPTH))); // R10
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int W   = 8,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  half_cnt,
  input  logic         tx_avail,
  input  logic [W-1:0] tx_word,
  output logic         tx_take,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         rx_done,
  output logic [W-1:0] rx_word,
  output logic         active
);
  logic [15:0]   tick;
  logic [BW-1:0] bitn;
  logic [W-1:0]  tx_sh, rx_sh;
  logic          edge_now, rise_ev, fall_ev, last_fall;

  assign edge_now  = active && (tick >= half_cnt - 16'd1);
  assign rise_ev   = edge_now && !sclk;
  assign fall_ev   = edge_now && sclk;
  assign last_fall = fall_ev && (bitn == BW'(W - 1));
  assign tx_take   = tx_avail && (!active || last_fall);
  assign rx_done   = last_fall;
  assign rx_word   = rx_sh;
  assign mosi      = tx_sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      tick   <= '0;
      bitn   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (tx_take) begin
      active <= 1'b1;
      sclk   <= 1'b0;
      tick   <= '0;
      bitn   <= '0;
      tx_sh  <= tx_word;
    end else if (last_fall) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      tick   <= '0;
    end else if (active) begin
      if (edge_now) begin
        tick <= '0;
        sclk <= ~sclk;
        if (rise_ev) rx_sh <= {rx_sh[W-2:0], miso};
        if (fall_ev) begin
          bitn  <= bitn + 1'b1;
          tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
      end else begin
        tick <= tick + 16'd1;
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk); // R1
  AST_MOSI_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi)); // R1
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && tx_avail) |=> (active && !sclk)); // R5
endmodule

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic             rx_empty,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [CW-1:0]    tx_level,
  input  logic [CW-1:0]    rx_level,
  input  logic             tx_irq_en,
  input  logic             rx_irq_en,
  input  logic             cs_force,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             busy,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             tx_ovf,
  output logic             rx_ovf
);
  import spi_fifo_pkg::*;

  logic [W-1:0]  tx_head, rx_word;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, tx_drop;
  logic          rx_full, rx_drop;
  logic          tx_take, rx_done, eng_active;
  logic [15:0]   half_cnt;

  assign half_cnt = sclk_half(16'(clk_div));

  spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .push(wr_en), .din(wr_data), .pop(tx_take),
    .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .dropped(tx_drop));

  spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_done), .din(rx_word), .pop(rd_en),
    .dout(rd_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .dropped(rx_drop));

  spi_shift_engine #(.W(W)) u_eng (
    .clk, .rst_n, .half_cnt, .tx_avail(!tx_empty), .tx_word(tx_head),
    .tx_take, .miso, .sclk, .mosi, .rx_done, .rx_word, .active(eng_active));

  assign busy   = eng_active || !tx_empty;
  assign cs_n   = !(busy || cs_force);
  assign tx_irq = tx_irq_en && level_below(8'(tx_cnt), 8'(tx_level));
  assign rx_irq = rx_irq_en && !level_below(8'(rx_cnt), 8'(rx_level));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      rx_ovf <= 1'b0;
    end else begin
      if (tx_drop) tx_ovf <= 1'b1;
      if (rx_drop) rx_ovf <= 1'b1;
    end
  end

  AST_CS_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_active && tx_empty && !cs_force) |-> cs_n); // R4
  AST_CS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_force |-> !cs_n); // R6
  AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf); // R9
  AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> rx_ovf); // R10
  AST_RX_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full) |=> rx_ovf); // R10
endmodule

// File: tb/sim_spi_fifo_master.sv
`timescale 1ns/1ps
module sim_spi_fifo_master;
  localparam int W = 8, DEPTH = 16, DIV_W = 8, CW = 5;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, tx_irq_en = 1, rx_irq_en = 1, cs_force = 0;
  logic [W-1:0] wr_data = '0;
  logic [DIV_W-1:0] clk_div = 8'd4;
  logic [CW-1:0] tx_level = 5'd4, rx_level = 5'd2;
  logic [W-1:0] rd_data;
  logic rx_empty, sclk, mosi, miso, cs_n, busy, tx_irq, rx_irq, tx_ovf, rx_ovf;

  always #10 clk = ~clk;

  spi_fifo_master #(.W(W), .DEPTH(DEPTH), .DIV_W(DIV_W)) u0 (
    .clk, .rst_n, .wr_en, .wr_data, .rd_en, .rd_data, .rx_empty, .clk_div,
    .tx_level, .rx_level, .tx_irq_en, .rx_irq_en, .cs_force, .sclk, .mosi,
    .miso, .cs_n, .busy, .tx_irq, .rx_irq, .tx_ovf, .rx_ovf);

  int checks = 0, errors = 0;
  logic [7:0] tx_exp[$];
  logic [7:0] rx_exp[$];

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(int k);
    return 8'(k * 37 + 5);
  endfunction

  // Slave model: mode 0, returns resp(k) for the k-th word.
  logic [7:0] slave_sh = resp(0);
  int slave_bits = 0, slave_k = 0;
  bit slave_reload = 0;
  assign miso = slave_sh[7];
  always @(posedge sclk) begin
    slave_bits++;
    if (slave_bits == 8) begin
      rx_exp.push_back(resp(slave_k));
      slave_k++;
      slave_bits = 0;
      slave_reload = 1;
    end
  end
  always @(negedge sclk) begin
    if (slave_reload) begin
      slave_sh = resp(slave_k);
      slave_reload = 0;
    end else slave_sh = {slave_sh[6:0], 1'b0};
  end

  // Monitor: collects MOSI words and scores them against the driver queue.
  logic [7:0] mon_sh = '0;
  int mon_bits = 0;
  time last_rise = 0, last_period = 0, max_gap = 0;
  bit gap_track = 0;
  int cs_rises = 0;
  always @(posedge cs_n) cs_rises++;
  always @(posedge sclk) begin
    mon_sh = {mon_sh[6:0], mosi};
    mon_bits++;
    if (last_rise != 0) begin
      last_period = $time - last_rise;
      if (gap_track && last_period > max_gap) max_gap = last_period;
    end
    last_rise = $time;
    if (mon_bits == 8) begin
      mon_bits = 0;
      if (tx_exp.size() == 0) chk_eq("R9", "unexpected mosi word", int'(mon_sh), -1);
      else chk_eq("R1 R3", "mosi word", int'(mon_sh), int'(tx_exp.pop_front()));
    end
  end

  task automatic send(logic [7:0] d, bit accepted = 1);
    wr_en = 1; wr_data = d;
    if (accepted) tx_exp.push_back(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic drain();
    while (!rx_empty) begin
      if (rx_exp.size() == 0) chk_eq("R3", "extra rx word", int'(rd_data), -1);
      else chk_eq("R1 R3", "rx word", int'(rd_data), int'(rx_exp.pop_front()));
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk_eq("R12", "cs_n", cs_n, 1);
    chk_eq("R12", "sclk", sclk, 0);
    chk_eq("R12", "busy", busy, 0);
    chk_eq("R12", "rx_empty", rx_empty, 1);
    chk_eq("R12", "ovf", {tx_ovf, rx_ovf}, 0);
    chk_eq("R12 R7", "tx_irq empty", tx_irq, 1);
    chk_eq("R12 R8", "rx_irq empty", rx_irq, 0);

    // Single word, divisor 4
    clk_div = 8'd4;
    send(8'hA5);
    chk_eq("R4", "cs_n after write", cs_n, 0);
    chk_eq("R11", "busy after write", busy, 1);
    wait_idle();
    chk_eq("R4", "cs_n after last word", cs_n, 1);
    chk_eq("R11", "busy idle", busy, 0);
    chk_eq("R2", "period div4", int'(last_period), 80);
    drain();

    // R2 divisor 6 and divisor below 2
    clk_div = 8'd6; send(8'h3C); wait_idle();
    chk_eq("R2", "period div6", int'(last_period), 120);
    clk_div = 8'd1; send(8'hC3); wait_idle();
    chk_eq("R2", "period div1 as 2", int'(last_period), 40);
    drain();

    // R5 back-to-back burst
    clk_div = 8'd2;
    gap_track = 1; last_rise = 0; max_gap = 0; r0 = cs_rises;
    send(8'h11); send(8'h22); send(8'h33);
    wait_idle();
    gap_track = 0;
    chk_eq("R5", "max rise interval", int'(max_gap), 40);
    chk_eq("R5", "cs rises in burst", cs_rises - r0, 1);
    drain();

    // R4 idle gap in automatic mode
    r0 = cs_rises;
    send(8'h5A); wait_idle(); send(8'hF0); wait_idle();
    chk_eq("R4", "cs rises across gap", cs_rises - r0, 2);
    drain();

    // R6 forced chip select
    cs_force = 1; @(negedge clk);
    chk_eq("R6", "cs_n forced idle", cs_n, 0);
    r0 = cs_rises;
    send(8'h81); wait_idle();
    chk_eq("R6", "cs_n held in gap", cs_n, 0);
    send(8'h7E); wait_idle();
    chk_eq("R6", "cs rises while forced", cs_rises - r0, 0);
    cs_force = 0; @(negedge clk);
    chk_eq("R4", "cs_n after release", cs_n, 1);
    drain();

    // R7 transmit level interrupt
    clk_div = 8'd8; tx_level = 5'd4;
    for (int i = 0; i < 5; i++) send(8'(8'h40 + i));
    chk_eq("R7", "tx_irq at count 4", tx_irq, 0);
    repeat (70) @(negedge clk);
    chk_eq("R7", "tx_irq at count 3", tx_irq, 1);
    tx_irq_en = 0; @(negedge clk);
    chk_eq("R7", "tx_irq disabled", tx_irq, 0);
    tx_irq_en = 1;
    wait_idle();
    drain();

    // R8 receive level interrupt
    rx_level = 5'd3; clk_div = 8'd2;
    send(8'h01); send(8'h02); wait_idle();
    chk_eq("R8", "rx_irq at 2", rx_irq, 0);
    send(8'h03); wait_idle();
    chk_eq("R8", "rx_irq at 3", rx_irq, 1);
    rx_irq_en = 0; @(negedge clk);
    chk_eq("R8", "rx_irq disabled", rx_irq, 0);
    rx_irq_en = 1;
    drain();
    chk_eq("R8", "rx_irq after drain", rx_irq, 0);

    // R9 / R10 overflow: 18 paced writes, first one loaded at once
    clk_div = 8'd16;
    for (int i = 1; i <= 18; i++) begin
      if (i == 18) chk_eq("R9", "tx_ovf before drop", tx_ovf, 0);
      send(8'(8'h90 + i), i <= 17);
      @(negedge clk);
    end
    chk_eq("R9", "tx_ovf after drop", tx_ovf, 1);
    wait_idle();
    chk_eq("R10", "rx_ovf", rx_ovf, 1);
    void'(rx_exp.pop_back());
    drain();
    chk_eq("R10", "rx_ovf sticky", rx_ovf, 1);
    chk_eq("R9", "tx_ovf sticky", tx_ovf, 1);
    chk_eq("R3", "unsent words", tx_exp.size(), 0);
    chk_eq("R3", "unread words", rx_exp.size(), 0);

    summary();
    $finish;
  end
endmodule